// File: doc/BRIEF.md
# Signed Restoring Sequential Divider

This block divides one two's-complement integer by another over several clock cycles and produces one quotient bit per cycle. A one-cycle start pulse loads a dividend and a divisor of `W` bits each. The block then steps through a restoring long division. In each step it shifts a double-width partial-remainder/quotient pair left by one bit. It then adds the divisor to the upper half, or subtracts it. Finally it keeps the trial result or puts back the old value, depending on whether the partial remainder stayed on the dividend's side of zero. A final cycle negates the quotient when the operand signs differ. The result then appears with a one-cycle done pulse.

The quotient is truncated toward zero. The remainder carries the sign of the dividend or is zero, so the identity dividend = quotient × divisor + remainder holds. Two operand pairs are screened at the start pulse and answered in one cycle without iterating. A zero divisor raises a divide-by-zero flag. The most negative value divided by −1, which has no representable quotient, raises an overflow flag. While a division is in progress `busy_o` is high and new start pulses are ignored.

Top module: `sdiv_restoring`

## Requirements
- R1: For a nonzero divisor, excluding the overflow pair, the result satisfies dividend = quotient × divisor + remainder. The quotient is truncated toward zero, the remainder is zero or has the dividend's sign (bit W−1), and |remainder| < |divisor|.
- R2: For an iterating division, `busy_o` is high for exactly W+1 cycles starting with the cycle after the accepting clock edge. `done_o` rises together with the fall of `busy_o`, which is W+2 clock edges after the start was sampled, counting the sampling edge as the first.
- R3: A start pulse that arrives while `busy_o` is high is ignored. The running division finishes at its normal time with its own operands.
- R4: A zero divisor is answered on the accepting edge. `done_o` and `div_zero_o` are high in the next cycle, quotient and remainder are zero, and `busy_o` stays low.
- R5: The most negative dividend (only bit W−1 set) with a divisor of all ones (−1) is answered on the accepting edge. `done_o` and `ovf_o` are high in the next cycle, the quotient is the most negative value and the remainder is zero.
- R6: `div_zero_o` and `ovf_o` are high only in a cycle where `done_o` is high. `done_o` is never high while `busy_o` is high.
- R7: A synchronous active-high reset, applied at any time, returns the block to idle. After it, `busy_o`, `done_o`, both flags, the quotient and the remainder are all zero.
- R8: Quotient and remainder change only on the edge that raises `done_o`. They hold their value in every later cycle until the next result.
- R9: An exact division, including one with a negative dividend, gives a zero remainder and the exact quotient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| dividend_i | input | W | Signed dividend, sampled with the start pulse |
| divisor_i | input | W | Signed divisor, sampled with the start pulse |
| busy_o | output | 1 | High while a division is iterating or being corrected |
| done_o | output | 1 | One-cycle pulse marking a new result |
| quotient_o | output | W | Signed quotient, held until the next result |
| remainder_o | output | W | Signed remainder, held until the next result |
| div_zero_o | output | 1 | Divisor was zero, valid with done |
| ovf_o | output | 1 | Quotient not representable, valid with done |

## Verification
The bench goes after negative dividends whose partial remainder reaches exactly zero while nonzero low dividend bits are still to be shifted in. A design that always accepted a zero trial result there would return a positive remainder for a negative dividend and a quotient one too large. The sweep includes divisors at both extremes of the range, where a trial sum wider than W bits would wrap. It includes the most negative dividend, whose final negation must wrap, and its pairing with −1, which must be flagged rather than returned as a wrapped quotient. It also checks a zero divisor, a start pulse during iteration (a design that re-armed would finish late with the intruding operands), and a reset in mid-division.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } sdiv_state_e;

endpackage

// File: rtl/sdiv_screen.sv
module sdiv_screen #(
    parameter int W = 8
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         div_zero,
    output logic         ovf_case,
    output logic         dvd_neg,
    output logic         flip,
    output logic [W-1:0] a_init
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_comb begin
        div_zero = (divisor == '0);
        ovf_case = (dividend == MOST_NEG) && (divisor == ALL_ONES);
        dvd_neg  = dividend[W-1];
        flip     = dividend[W-1] ^ divisor[W-1];
        a_init   = {W{dividend[W-1]}};
    end

endmodule

// File: rtl/sdiv_iter.sv
module sdiv_iter #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_cur,
    input  logic [W-1:0] q_cur,
    input  logic [W-1:0] tail_cur,
    input  logic [W-1:0] m_cur,
    input  logic         dvd_neg,
    output logic [W-1:0] a_nxt,
    output logic [W-1:0] q_nxt,
    output logic [W-1:0] tail_nxt
);
    logic [W-1:0] a_sh;
    logic [W-1:0] q_sh;
    logic [W:0]   a_ext;
    logic [W:0]   m_ext;
    logic [W:0]   trial;
    logic         use_sub;
    logic         trial_zero;
    logic         kept;

    always_comb begin
        a_sh     = {a_cur[W-2:0], q_cur[W-1]};
        q_sh     = {q_cur[W-2:0], 1'b0};
        tail_nxt = {tail_cur[W-2:0], 1'b0};
        a_ext    = {a_sh[W-1], a_sh};
        m_ext    = {m_cur[W-1], m_cur};
        // Move toward zero: subtract when divisor and dividend agree in sign.
        use_sub  = (dvd_neg == m_cur[W-1]);
        trial    = use_sub ? (a_ext - m_ext) : (a_ext + m_ext);
        trial_zero = (trial == '0);
        // A zero trial on the negative side is only a true zero when no
        // nonzero dividend bits remain to be shifted in.
        if (dvd_neg) begin
            kept = trial[W] || (trial_zero && (tail_nxt == '0));
        end else begin
            kept = !trial[W];
        end
        a_nxt = kept ? trial[W-1:0] : a_sh;
        q_nxt = {q_sh[W-1:1], kept};
    end

endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix #(
    parameter int W = 8
) (
    input  logic [W-1:0] q_raw,
    input  logic [W-1:0] a_raw,
    input  logic         flip,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    always_comb begin
        quo = flip ? (~q_raw + 1'b1) : q_raw;
        rem = a_raw;
    end

endmodule

// File: rtl/sdiv_restoring.sv
module sdiv_restoring
    import sdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o,
    output logic         div_zero_o,
    output logic         ovf_o
);
    localparam int           CW       = $clog2(W + 1);
    localparam logic [CW-1:0] LAST    = CW'(W - 1);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        sdiv_state_e   st;
        logic [CW-1:0] cnt;
        logic [W-1:0]  m;
        logic [W-1:0]  a;
        logic [W-1:0]  q;
        logic [W-1:0]  tail;
        logic          neg_dvd;
        logic          flip;
        logic          done;
        logic          dz;
        logic          ov;
        logic [W-1:0]  quo;
        logic [W-1:0]  rem;
    } sdiv_regs_t;

    sdiv_regs_t r_q;
    sdiv_regs_t r_d;

    logic         scr_dz;
    logic         scr_ov;
    logic         scr_neg;
    logic         scr_flip;
    logic [W-1:0] scr_a;
    logic [W-1:0] it_a;
    logic [W-1:0] it_q;
    logic [W-1:0] it_tail;
    logic [W-1:0] fx_quo;
    logic [W-1:0] fx_rem;

    sdiv_screen #(.W(W)) u_screen (
        .dividend (dividend_i),
        .divisor  (divisor_i),
        .div_zero (scr_dz),
        .ovf_case (scr_ov),
        .dvd_neg  (scr_neg),
        .flip     (scr_flip),
        .a_init   (scr_a)
    );

    sdiv_iter #(.W(W)) u_iter (
        .a_cur    (r_q.a),
        .q_cur    (r_q.q),
        .tail_cur (r_q.tail),
        .m_cur    (r_q.m),
        .dvd_neg  (r_q.neg_dvd),
        .a_nxt    (it_a),
        .q_nxt    (it_q),
        .tail_nxt (it_tail)
    );

    sdiv_fix #(.W(W)) u_fix (
        .q_raw (r_q.q),
        .a_raw (r_q.a),
        .flip  (r_q.flip),
        .quo   (fx_quo),
        .rem   (fx_rem)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.dz   = 1'b0;
        r_d.ov   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (scr_dz) begin
                        r_d.done = 1'b1;
                        r_d.dz   = 1'b1;
                        r_d.quo  = '0;
                        r_d.rem  = '0;
                    end else if (scr_ov) begin
                        r_d.done = 1'b1;
                        r_d.ov   = 1'b1;
                        r_d.quo  = MOST_NEG;
                        r_d.rem  = '0;
                    end else begin
                        r_d.st      = ST_RUN;
                        r_d.cnt     = '0;
                        r_d.m       = divisor_i;
                        r_d.a       = scr_a;
                        r_d.q       = dividend_i;
                        r_d.tail    = dividend_i;
                        r_d.neg_dvd = scr_neg;
                        r_d.flip    = scr_flip;
                    end
                end
            end
            ST_RUN: begin
                r_d.a    = it_a;
                r_d.q    = it_q;
                r_d.tail = it_tail;
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.st = ST_FIX;
                end
            end
            ST_FIX: begin
                r_d.quo  = fx_quo;
                r_d.rem  = fx_rem;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign quotient_o  = r_q.quo;
    assign remainder_o = r_q.rem;
    assign div_zero_o  = r_q.dz;
    assign ovf_o       = r_q.ov;

endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [W-1:0] dividend_i,
    input logic [W-1:0] divisor_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] quotient_o,
    input logic [W-1:0] remainder_o,
    input logic         div_zero_o,
    input logic         ovf_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0]          cap_a;
    logic [W-1:0]          cap_b;
    logic [15:0]           bcnt;
    logic signed [2*W+1:0] qx;
    logic signed [2*W+1:0] bx;
    logic signed [2*W+1:0] rx;
    logic signed [2*W+1:0] ax;
    logic signed [2*W+1:0] recon;
    logic [W:0]            r_abs;
    logic [W:0]            b_abs;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a <= '0;
            cap_b <= '0;
            bcnt  <= '0;
        end else begin
            if (start_i && !busy_o) begin
                cap_a <= dividend_i;
                cap_b <= divisor_i;
            end
            bcnt <= busy_o ? (bcnt + 16'd1) : 16'd0;
        end
    end

    always_comb begin
        qx    = {{(W+2){quotient_o[W-1]}}, quotient_o};
        bx    = {{(W+2){cap_b[W-1]}}, cap_b};
        rx    = {{(W+2){remainder_o[W-1]}}, remainder_o};
        ax    = {{(W+2){cap_a[W-1]}}, cap_a};
        recon = qx * bx + rx;
        r_abs = remainder_o[W-1] ? (~{1'b1, remainder_o} + 1'b1) : {1'b0, remainder_o};
        b_abs = cap_b[W-1] ? (~{1'b1, cap_b} + 1'b1) : {1'b0, cap_b};
    end

    // R1
    identity_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !div_zero_o && !ovf_o) |->
            ((recon == ax) && (r_abs < b_abs) &&
             ((remainder_o == '0) || (remainder_o[W-1] == cap_a[W-1]))));

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (bcnt != 16'd0)) |-> ((bcnt == 16'(W + 1)) && done_o));

    // R4
    div_zero_chk: assert property (@(posedge clk) disable iff (rst)
        div_zero_o |-> ((quotient_o == '0) && (remainder_o == '0) && (cap_b == '0)));

    // R5
    ovf_value_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> ((quotient_o == MOST_NEG) && (remainder_o == '0) && !div_zero_o));

    // R6
    flag_done_chk: assert property (@(posedge clk) disable iff (rst)
        (div_zero_o || ovf_o) |-> done_o);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !done_o && (quotient_o == '0) && (remainder_o == '0)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !$past(rst)) |-> ($stable(quotient_o) && $stable(remainder_o)));

endmodule

bind sdiv_restoring sdiv_checker #(.W(W)) u_chk (.*);

// File: tb/sdiv_restoring_tb.sv
module sdiv_restoring_tb;
    localparam int W    = 8;
    localparam int MAXV = (2 ** (W - 1)) - 1;
    localparam int MINV = -(2 ** (W - 1));

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] quotient_o;
    logic [W-1:0] remainder_o;
    logic         div_zero_o;
    logic         ovf_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    sdiv_restoring #(.W(W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o),
        .div_zero_o  (div_zero_o),
        .ovf_o       (ovf_o)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] divisor_of(input int j);
        int v;
        if (j < 21)       v = j;
        else if (j < 41)  v = -(j - 20);
        else begin
            case (j)
                41: v = MAXV;
                42: v = MINV;
                43: v = MAXV - 1;
                44: v = MINV + 1;
                45: v = 2 ** (W - 2);
                46: v = -(2 ** (W - 2));
                default: v = 37;
            endcase
        end
        return W'(v);
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge where done is seen.
    task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
        int ia, ib, eq, er, exp_lat, lat;
        logic edz, eov;
        string tag;
        ia = $signed(a);
        ib = $signed(b);
        edz = 1'b0;
        eov = 1'b0;
        if (ib == 0) begin
            eq = 0; er = 0; edz = 1'b1; exp_lat = 0; tag = "R4";
        end else if (ia == MINV && ib == -1) begin
            eq = MINV; er = 0; eov = 1'b1; exp_lat = 0; tag = "R5";
        end else begin
            eq = ia / ib; er = ia % ib; exp_lat = W + 1;
            tag = (er == 0) ? "R9" : "R1";
        end
        if (poke) tag = "R3";
        start_i    = 1'b1;
        dividend_i = a;
        divisor_i  = b;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        if (exp_lat != 0) check_bit("R2 busy after start", busy_o, 1'b1);
        while (!done_o && lat < 4 * W) begin
            if (poke && lat == 3) begin
                start_i    = 1'b1;
                dividend_i = W'(1);
                divisor_i  = '0;
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        check_val("R2 latency", lat, exp_lat);
        vectors++;
        if (int'($signed(quotient_o)) != eq || int'($signed(remainder_o)) != er ||
            div_zero_o !== edz || ovf_o !== eov) begin
            miscompares++;
            $display("FAIL %s: a=%0d b=%0d actual q=%0d r=%0d dz=%0b ov=%0b expected q=%0d r=%0d dz=%0b ov=%0b",
                     tag, ia, ib, $signed(quotient_o), $signed(remainder_o), div_zero_o, ovf_o,
                     eq, er, edz, eov);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL R2: watchdog expired, actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] hq, hr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R7: state after reset
        check_bit("R7 busy", busy_o, 1'b0);
        check_bit("R7 done", done_o, 1'b0);
        check_bit("R7 div_zero", div_zero_o, 1'b0);
        check_bit("R7 ovf", ovf_o, 1'b0);
        check_val("R7 quotient", int'(quotient_o), 0);
        check_val("R7 remainder", int'(remainder_o), 0);

        // R9 exact negatives, R1 mixed signs, extremes
        do_op(W'(-7), W'(2), 1'b0);
        do_op(W'(-8), W'(2), 1'b0);
        do_op(W'(MINV), W'(1), 1'b0);
        do_op(W'(MINV), W'(MINV), 1'b0);
        do_op(W'(MAXV), W'(MINV), 1'b0);
        do_op(W'(MINV), W'(-1), 1'b0);
        do_op(W'(5), '0, 1'b0);

        // R6: flags drop once done has passed
        @(posedge clk);
        @(negedge clk);
        check_bit("R6 div_zero after done", div_zero_o, 1'b0);
        check_bit("R6 done after pulse", done_o, 1'b0);

        // R8: result holds while idle
        do_op(W'(-100), W'(7), 1'b0);
        hq = quotient_o;
        hr = remainder_o;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_val("R8 quotient hold", int'(quotient_o), int'(hq));
            check_val("R8 remainder hold", int'(remainder_o), int'(hr));
            check_bit("R8 done low", done_o, 1'b0);
        end

        // R3: start during iteration is ignored
        do_op(W'(100), W'(-9), 1'b1);
        do_op(W'(-128 + 3), W'(5), 1'b1);

        // R7: reset in mid-division
        start_i    = 1'b1;
        dividend_i = W'(77);
        divisor_i  = W'(3);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_bit("R7 busy after mid reset", busy_o, 1'b0);
        check_bit("R7 done after mid reset", done_o, 1'b0);
        check_val("R7 quotient after mid reset", int'(quotient_o), 0);
        check_val("R7 remainder after mid reset", int'(remainder_o), 0);

        // R1 R4 R5 R9: sweep every dividend against a divisor set
        for (int i = 0; i < 2 ** W; i++) begin
            for (int j = 0; j < 48; j++) begin
                do_op(W'(i), divisor_of(j), 1'b0);
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule